// File: doc/BRIEF.md
# Global Clock Spine Selector

This block sits at the centre of a clock distribution network and decides which of 36 candidate clock sources drives each global spine. There are two independent banks, one per half of the die, each serving 8 spines, so a given spine number can carry a different source in each half. The selection is modelled as a registered data-path multiplexer: the chosen source is sampled on every rising edge of the block clock and presented on the spine output.

A spine is programmed through a single-cycle write port with three parts: a row field, a column field (both 6 bits wide) and an enable bit. When the spine is enabled and each field has exactly one bit set, row bit i and column bit j pick source 6*j + i. Sources 0 to 33 are the horizontal trunk clocks. Sources 34 and 35 are the two direct clock inputs. A spine that is enabled but whose fields are not both one-hot is held low, and that half raises a configuration error flag.

Top module: `gcs_spine_select`

## Requirements
- R1: While rst is high and on the first edge after it, every spine output and both error flags are 0, and every spine is left disabled.
- R2: A cycle with cfg_we high loads cfg_row, cfg_col and cfg_en into spine cfg_spine of half cfg_half at that rising edge. No other spine changes.
- R3: An enabled spine whose row field has only bit i set and whose column field has only bit j set drives src_in[6*j+i]. The value is sampled at the rising edge, so a configuration written at edge k first shows at edge k+1.
- R4: The direct clock inputs are reached with column bit 5 and row bit 4 (index 34) or row bit 5 (index 35). Trunk clocks occupy indices 0 to 33.
- R5: A row field of 000001 with a column field of 000001 is a valid selection of source 0.
- R6: A spine whose enable is 0 drives 0, whatever its row and column fields hold.
- R7: An enabled spine whose row or column field is zero or has more than one bit set drives 0, and the error flag of its half is set on the same edge.
- R8: cfg_err[h] is 1 exactly when some spine of half h was enabled with an invalid field at the previous edge. It clears once that spine is corrected or disabled. It never reflects the other half.
- R9: spine_out bit h*8+s belongs to spine s of half h. The two halves hold separate configurations for the same spine number.
- R10: A disabled spine with invalid fields raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_half | input | 1 | Half selected by the write |
| cfg_spine | input | 3 | Spine within the half |
| cfg_row | input | 6 | One-hot row field |
| cfg_col | input | 6 | One-hot column field |
| cfg_en | input | 1 | Spine enable |
| src_in | input | 36 | Candidate clock sources |
| spine_out | output | 16 | Registered spine outputs, half-major order |
| cfg_err | output | 2 | Per-half invalid configuration flag |

## Verification
The assertions assume that the write inputs and the sources are steady around each rising edge. They also assume that reset is applied at power-up, because the checker compares each output against the configuration state of the previous cycle. The stimulus changes every input only on the falling edge and opens the run with reset held for several cycles. Random row and column fields are biased toward one-hot values, so valid selections dominate while zero and multi-bit fields still appear often enough to drive the error path.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  localparam int FIELD_W = 6;
  localparam int NUM_SRC = FIELD_W * FIELD_W;
  localparam int POS_W   = $clog2(FIELD_W);
  localparam int SRC_IDX_W = $clog2(NUM_SRC);

  typedef struct packed {
    logic               en;
    logic [FIELD_W-1:0] row;
    logic [FIELD_W-1:0] col;
  } spine_cfg_t;
endpackage

// File: rtl/gcs_cfg_bank.sv
module gcs_cfg_bank
  import gcs_pkg::*;
#(
  parameter int SPINES = 8,
  localparam int IDX_W = $clog2(SPINES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  spine_cfg_t               wr_cfg,
  output spine_cfg_t [SPINES-1:0]  cfg_q
);
  for (genvar s = 0; s < SPINES; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[s] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(s)) begin
        cfg_q[s] <= wr_cfg;
      end
    end
  end
endmodule

// File: rtl/gcs_onehot_dec.sv
module gcs_onehot_dec #(
  parameter int W = 6,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          valid,
  output logic [PW-1:0] pos
);
  always_comb begin
    valid = (vec != '0) && ((vec & (vec - W'(1))) == '0);
    pos   = '0;
    for (int b = 0; b < W; b++) begin
      if (vec[b]) pos = pos | PW'(b);
    end
  end
endmodule

// File: rtl/gcs_spine_mux.sv
module gcs_spine_mux
  import gcs_pkg::*;
(
  input  spine_cfg_t         cfg,
  input  logic [NUM_SRC-1:0] src,
  output logic               sel,
  output logic               bad
);
  logic             row_ok, col_ok;
  logic [POS_W-1:0] row_pos, col_pos;
  logic [SRC_IDX_W-1:0] idx;

  gcs_onehot_dec #(.W(FIELD_W)) u_row (.vec(cfg.row), .valid(row_ok), .pos(row_pos));
  gcs_onehot_dec #(.W(FIELD_W)) u_col (.vec(cfg.col), .valid(col_ok), .pos(col_pos));

  always_comb begin
    idx = SRC_IDX_W'(col_pos) * SRC_IDX_W'(FIELD_W) + SRC_IDX_W'(row_pos);
    bad = cfg.en && !(row_ok && col_ok);
    sel = (cfg.en && row_ok && col_ok) ? src[idx] : 1'b0;
  end
endmodule

// File: rtl/gcs_spine_select.sv
module gcs_spine_select
  import gcs_pkg::*;
#(
  parameter int SPINES_PER_HALF = 8,
  parameter int HALVES = 2,
  localparam int TOTAL  = SPINES_PER_HALF * HALVES,
  localparam int SP_W   = $clog2(SPINES_PER_HALF),
  localparam int HALF_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [HALF_W-1:0]  cfg_half,
  input  logic [SP_W-1:0]    cfg_spine,
  input  logic [FIELD_W-1:0] cfg_row,
  input  logic [FIELD_W-1:0] cfg_col,
  input  logic               cfg_en,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [TOTAL-1:0]   spine_out,
  output logic [HALVES-1:0]  cfg_err
);
  spine_cfg_t [TOTAL-1:0] cfg_all;
  spine_cfg_t             wr_cfg;
  logic [TOTAL-1:0]       sel_d;
  logic [TOTAL-1:0]       bad_d;

  assign wr_cfg = '{en: cfg_en, row: cfg_row, col: cfg_col};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    gcs_cfg_bank #(.SPINES(SPINES_PER_HALF)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .wr_en (cfg_we && cfg_half == HALF_W'(h)),
      .wr_idx(cfg_spine),
      .wr_cfg(wr_cfg),
      .cfg_q (cfg_all[h*SPINES_PER_HALF +: SPINES_PER_HALF])
    );

    for (genvar s = 0; s < SPINES_PER_HALF; s++) begin : g_spine
      gcs_spine_mux u_mux (
        .cfg(cfg_all[h*SPINES_PER_HALF + s]),
        .src(src_in),
        .sel(sel_d[h*SPINES_PER_HALF + s]),
        .bad(bad_d[h*SPINES_PER_HALF + s])
      );
    end

    always_ff @(posedge clk) begin
      if (rst) cfg_err[h] <= 1'b0;
      else     cfg_err[h] <= |bad_d[h*SPINES_PER_HALF +: SPINES_PER_HALF];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) spine_out <= '0;
    else     spine_out <= sel_d;
  end
endmodule

// File: rtl/gcs_spine_select_chk.sv
module gcs_spine_select_chk
  import gcs_pkg::*;
#(
  parameter int SPINES_PER_HALF = 8,
  parameter int HALVES = 2,
  localparam int TOTAL  = SPINES_PER_HALF * HALVES,
  localparam int SP_W   = $clog2(SPINES_PER_HALF),
  localparam int HALF_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfg_we,
  input logic [HALF_W-1:0]      cfg_half,
  input logic [SP_W-1:0]        cfg_spine,
  input logic [FIELD_W-1:0]     cfg_row,
  input logic [FIELD_W-1:0]     cfg_col,
  input logic                   cfg_en,
  input logic [NUM_SRC-1:0]     src_in,
  input logic [TOTAL-1:0]       spine_out,
  input logic [HALVES-1:0]      cfg_err,
  input spine_cfg_t [TOTAL-1:0] cfg_all
);
  logic [SRC_IDX_W-1:0] ref_idx [TOTAL];
  logic [TOTAL-1:0]     good;
  logic [TOTAL-1:0]     broken;
  logic [HALVES-1:0]    broken_any;

  always_comb begin
    for (int g = 0; g < TOTAL; g++) begin
      ref_idx[g] = '0;
      for (int j = 0; j < FIELD_W; j++)
        for (int i = 0; i < FIELD_W; i++)
          if (cfg_all[g].row[i] && cfg_all[g].col[j]) ref_idx[g] = SRC_IDX_W'(j*FIELD_W + i);
      good[g]   = cfg_all[g].en && $onehot(cfg_all[g].row) && $onehot(cfg_all[g].col);
      broken[g] = cfg_all[g].en && !($onehot(cfg_all[g].row) && $onehot(cfg_all[g].col));
    end
    for (int h = 0; h < HALVES; h++)
      broken_any[h] = |broken[h*SPINES_PER_HALF +: SPINES_PER_HALF];
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (spine_out == '0 && cfg_err == '0));

  for (genvar g = 0; g < TOTAL; g++) begin : g_sp
    localparam int H = g / SPINES_PER_HALF;
    localparam int S = g % SPINES_PER_HALF;

    assert_write_load_R2: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_half == HALF_W'(H) && cfg_spine == SP_W'(S)) |=>
        (cfg_all[g].en == $past(cfg_en) && cfg_all[g].row == $past(cfg_row)
         && cfg_all[g].col == $past(cfg_col)));

    assert_other_half_kept_R9: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_half != HALF_W'(H)) |=> $stable(cfg_all[g]));

    assert_pick_source_R3: assert property (@(posedge clk) disable iff (rst)
      good[g] |=> spine_out[g] == $past(src_in[ref_idx[g]]));

    assert_off_is_low_R6: assert property (@(posedge clk) disable iff (rst)
      !cfg_all[g].en |=> !spine_out[g]);

    assert_bad_is_low_R7: assert property (@(posedge clk) disable iff (rst)
      broken[g] |=> !spine_out[g]);
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_hf
    assert_err_raise_R7: assert property (@(posedge clk) disable iff (rst)
      broken_any[h] |=> cfg_err[h]);
    assert_err_drop_R8: assert property (@(posedge clk) disable iff (rst)
      !broken_any[h] |=> !cfg_err[h]);
  end
endmodule

bind gcs_spine_select gcs_spine_select_chk #(
  .SPINES_PER_HALF(SPINES_PER_HALF),
  .HALVES(HALVES)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_half(cfg_half),
  .cfg_spine(cfg_spine), .cfg_row(cfg_row), .cfg_col(cfg_col),
  .cfg_en(cfg_en), .src_in(src_in), .spine_out(spine_out),
  .cfg_err(cfg_err), .cfg_all(cfg_all)
);

// File: tb/test_gcs_spine_select.sv
module test_gcs_spine_select;
  localparam int CLK_PERIOD = 10;
  localparam int SP = 8;
  localparam int NT = 16;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_half = '0;
  logic [2:0]  cfg_spine = '0;
  logic [5:0]  cfg_row = '0;
  logic [5:0]  cfg_col = '0;
  logic        cfg_en = 1'b0;
  logic [35:0] src_in = '0;
  logic [15:0] spine_out;
  logic [1:0]  cfg_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic       m_en  [NT];
  logic [5:0] m_row [NT];
  logic [5:0] m_col [NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  gcs_spine_select i_gcs_spine_select (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_half(cfg_half),
    .cfg_spine(cfg_spine), .cfg_row(cfg_row), .cfg_col(cfg_col),
    .cfg_en(cfg_en), .src_in(src_in), .spine_out(spine_out), .cfg_err(cfg_err)
  );

  function automatic logic exp_spine(int g, logic [35:0] s);
    if (!m_en[g]) return 1'b0;
    if ($countones(m_row[g]) != 1 || $countones(m_col[g]) != 1) return 1'b0;
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < 6; i++)
        if (m_row[g][i] && m_col[g][j]) return s[6*j + i];
    return 1'b0;
  endfunction

  function automatic logic exp_err(int h);
    logic e = 1'b0;
    for (int s = 0; s < SP; s++) begin
      int g = h*SP + s;
      if (m_en[g] && ($countones(m_row[g]) != 1 || $countones(m_col[g]) != 1)) e = 1'b1;
    end
    return e;
  endfunction

  function automatic logic [5:0] rand_field();
    if ($urandom % 10 < 7) return 6'(1) << ($urandom % 6);
    return 6'($urandom % 64);
  endfunction

  task automatic write_cfg(int h, int s, logic [5:0] r, logic [5:0] c, logic e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_half = 1'(h); cfg_spine = 3'(s);
    cfg_row = r; cfg_col = c; cfg_en = e;
    @(negedge clk);
    cfg_we = 1'b0;
    m_en[h*SP+s] = e; m_row[h*SP+s] = r; m_col[h*SP+s] = c;
  endtask

  // Drive the sources on a falling edge, let one rising edge pass, compare.
  task automatic check(logic [35:0] s, string tag);
    logic [15:0] eo;
    logic [1:0]  ee;
    src_in = s;
    @(negedge clk);
    for (int g = 0; g < NT; g++) eo[g] = exp_spine(g, s);
    ee = {exp_err(1), exp_err(0)};
    n_run++;
    if (spine_out !== eo || cfg_err !== ee) begin
      n_fail++;
      $display("FAIL %s: spine_out=%h cfg_err=%b expected spine_out=%h cfg_err=%b",
               tag, spine_out, cfg_err, eo, ee);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_set;
    seed_set = $urandom(32'h5eed);
    for (int g = 0; g < NT; g++) begin
      m_en[g] = 1'b0; m_row[g] = '0; m_col[g] = '0;
    end
    src_in = '1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check('1, "R1");

    // R5: lone bit 0 in both fields picks source 0
    write_cfg(0, 0, 6'b000001, 6'b000001, 1'b1);
    check(36'h1, "R5");
    check(~36'h1, "R5");

    // R6: disabled spine with a valid selection stays low
    write_cfg(0, 2, 6'b000010, 6'b000100, 1'b0);
    check('1, "R6");

    // R10: disabled spine with invalid fields raises no error
    write_cfg(1, 3, 6'b000000, 6'b110000, 1'b0);
    check('1, "R10");

    // R7: enabled with two row bits -> low and error in half 0 only (R8)
    write_cfg(0, 4, 6'b000011, 6'b000001, 1'b1);
    check('1, "R7");
    write_cfg(0, 4, 6'b000010, 6'b000000, 1'b1);
    check('1, "R7");
    write_cfg(0, 4, 6'b000010, 6'b000001, 1'b1);
    check('1, "R8");

    // R4: direct clock inputs at 34 and 35
    write_cfg(1, 6, 6'b010000, 6'b100000, 1'b1);
    write_cfg(1, 7, 6'b100000, 6'b100000, 1'b1);
    check(36'h4_0000_0000, "R4");
    check(36'h8_0000_0000, "R4");

    // R9: same spine number, different source per half
    write_cfg(0, 5, 6'b000010, 6'b000010, 1'b1);
    write_cfg(1, 5, 6'b000001, 6'b100000, 1'b1);
    check(36'h0_0000_0080, "R9");
    check(36'h0_4000_0000, "R9");

    // R3, R2: every (row, col) pair in both halves
    for (int h = 0; h < 2; h++)
      for (int j = 0; j < 6; j++)
        for (int i = 0; i < 6; i++) begin
          logic [35:0] one = 36'(1) << (6*j + i);
          write_cfg(h, (6*j + i) % SP, 6'(1) << i, 6'(1) << j, 1'b1);
          check(one, "R3");
          check(~one, "R2");
        end

    // Random configurations and sources
    for (int k = 0; k < 300; k++) begin
      write_cfg($urandom % 2, $urandom % SP, rand_field(), rand_field(), ($urandom % 4) != 0);
      check(36'({$urandom, $urandom}), "R3");
    end

    // R1: reset in mid-run clears outputs and configuration
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int g = 0; g < NT; g++) begin
      m_en[g] = 1'b0; m_row[g] = '0; m_col[g] = '0;
    end
    check('1, "R1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule